// File: doc/BRIEF.md
# Four-Channel Legacy DMA Register File

This block is the software-visible register set of a four-channel legacy DMA controller. A host reaches it through a narrow I/O port: a 4-bit register offset, an 8-bit write bus, an 8-bit read bus and separate write and read strobes. Each channel owns a 16-bit transfer address and a 16-bit transfer count. Both are moved a byte at a time through one port each, and one byte-pointer flip-flop shared by all eight of those ports picks the half.

Besides the per-channel words the block keeps a mode field for each channel, four mask bits, a command byte whose bit 2 switches the whole controller off, a software request bit per channel, and terminal-count flags. A status read merges the request lines with the terminal-count flags. A transfer engine outside this block consumes the words, modes and masks, and it reports terminal counts through a pulse input. There are also write-only command offsets that reset the byte pointer, perform a master clear, or change all the masks at once.

Top module: `legacy_dma_regs`

## Requirements
- R1: After reset all four mask bits are 1. The byte pointer selects the low byte. The command byte, the modes, the software requests, the terminal-count flags and every address and count word are 0.
- R2: Offset 2n is the address port of channel n and offset 2n+1 is its count port (n = 0..3). A write stores the byte into both the base and the current copy of that word, in the half the byte pointer selects. A read returns that half of the current copy.
- R3: The byte pointer is shared by all eight word ports. It flips after every read or write of offsets 0 to 7, so the low byte is accessed first and the high byte second.
- R4: A write to offset 12 sets the byte pointer to the low half, whatever the data.
- R5: A write to offset 13 (master clear) sets all four masks, clears the terminal-count flags and the software requests, and sets the byte pointer to low.
- R6: A write to offset 10 changes one mask: data bits 1:0 pick the channel, and bit 2 is the new mask value (1 = masked).
- R7: A write to offset 14 clears all four masks. A write to offset 15 copies data bit n into the mask of channel n.
- R8: A write to offset 11 stores data bits 7:2 as the mode of the channel that bits 1:0 pick. The mode appears at mode_o bits [6n+5:6n] (within it: [5:4] service kind, [3] decrement, [2] auto-initialise, [1:0] transfer type).
- R9: A write to offset 8 stores the command byte on cmd_o, and ctrl_off_o follows command bit 2.
- R10: A read of offset 8 returns the terminal-count flags in bits 3:0 and, in bits 7:4, request line n ORed with software request n. The read clears the terminal-count flags. A tc_i pulse sets its flag, and a pulse in the same cycle as the clearing read is kept.
- R11: A write to offset 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the software request of the channel that bits 1:0 pick.
- R12: io_rdata is 0 whenever io_rd is low, and on reads of offsets 9 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_rdata | output | 8 | Read data, combinational on the offset |
| dreq_i | input | 4 | Request line per channel, shown in status |
| tc_i | input | 4 | Terminal-count pulse per channel from the engine |
| mask_o | output | 4 | Mask bit per channel |
| cmd_o | output | 8 | Command byte |
| ctrl_off_o | output | 1 | Controller disabled (command bit 2) |
| mode_o | output | 24 | Channel modes, 6 bits per channel |
| base_addr_o | output | 64 | Base addresses, 16 bits per channel |
| cur_addr_o | output | 64 | Current addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Base counts, 16 bits per channel |
| cur_cnt_o | output | 64 | Current counts, 16 bits per channel |

## Verification
The bench loads every word port with a distinct pattern and reads each one back. It then interleaves bytes across different ports to show that a single pointer is shared: a design with one pointer per port would put the second byte in the low half of the other word. It sweeps all sixteen values of the all-mask write, sets and clears each single mask in turn, and checks the pointer reset after a high-byte write and after master clear. On the status register it checks that the flags clear on read, that request bits survive the read, and that a terminal-count pulse landing on the clearing read is kept; a design that lets the clear win would lose that event.

// File: rtl/legacy_dma_pkg.sv
package legacy_dma_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int OFF_W  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int MODE_W = BYTE_W - CH_W;

    localparam logic [OFF_W-1:0] OFF_CMD    = 4'd8;
    localparam logic [OFF_W-1:0] OFF_REQ    = 4'd9;
    localparam logic [OFF_W-1:0] OFF_ONEMSK = 4'd10;
    localparam logic [OFF_W-1:0] OFF_MODE   = 4'd11;
    localparam logic [OFF_W-1:0] OFF_PTRCLR = 4'd12;
    localparam logic [OFF_W-1:0] OFF_MCLR   = 4'd13;
    localparam logic [OFF_W-1:0] OFF_UNMASK = 4'd14;
    localparam logic [OFF_W-1:0] OFF_ALLMSK = 4'd15;

    typedef struct packed {
        logic [1:0] svc;
        logic       dec;
        logic       autoi;
        logic [1:0] xfer;
    } chan_mode_t;
endpackage

// File: rtl/dma_word_pair.sv
module dma_word_pair
    import legacy_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [WORD_W-1:0] base_addr,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] base_cnt,
    output logic [WORD_W-1:0] cur_cnt
);
    typedef struct packed {
        logic [WORD_W-1:0] ba;
        logic [WORD_W-1:0] ca;
        logic [WORD_W-1:0] bc;
        logic [WORD_W-1:0] cc;
    } words_t;

    words_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_addr) begin
            if (hi_sel) begin
                st_d.ba[WORD_W-1:BYTE_W] = wbyte;
                st_d.ca[WORD_W-1:BYTE_W] = wbyte;
            end else begin
                st_d.ba[BYTE_W-1:0] = wbyte;
                st_d.ca[BYTE_W-1:0] = wbyte;
            end
        end
        if (ld_cnt) begin
            if (hi_sel) begin
                st_d.bc[WORD_W-1:BYTE_W] = wbyte;
                st_d.cc[WORD_W-1:BYTE_W] = wbyte;
            end else begin
                st_d.bc[BYTE_W-1:0] = wbyte;
                st_d.cc[BYTE_W-1:0] = wbyte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_addr = st_q.ba;
    assign cur_addr  = st_q.ca;
    assign base_cnt  = st_q.bc;
    assign cur_cnt   = st_q.cc;
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
    import legacy_dma_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [OFF_W-1:0]         addr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic [NUM_CH-1:0]        tc_i,
    output logic                     ptr_hi_o,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [NUM_CH-1:0]        tc_o,
    output logic [NUM_CH-1:0]        sreq_o,
    output logic [BYTE_W-1:0]        cmd_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic                          ptr_hi;
        logic [NUM_CH-1:0]             mask;
        logic [NUM_CH-1:0]             tc;
        logic [NUM_CH-1:0]             sreq;
        logic [BYTE_W-1:0]             cmd;
        chan_mode_t [NUM_CH-1:0]       mode;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  [CH_W-1:0] ch_sel;
    logic  word_port;

    assign ch_sel    = wdata[CH_W-1:0];
    assign word_port = !addr[OFF_W-1];

    always_comb begin
        st_d = st_q;
        if ((wr_en || rd_en) && word_port)
            st_d.ptr_hi = !st_q.ptr_hi;
        if (rd_en && !wr_en && addr == OFF_CMD)
            st_d.tc = '0;
        if (wr_en) begin
            case (addr)
                OFF_CMD:    st_d.cmd = wdata;
                OFF_REQ:    st_d.sreq[ch_sel] = wdata[2];
                OFF_ONEMSK: st_d.mask[ch_sel] = wdata[2];
                OFF_MODE:   st_d.mode[ch_sel] = chan_mode_t'(wdata[BYTE_W-1:CH_W]);
                OFF_PTRCLR: st_d.ptr_hi = 1'b0;
                OFF_MCLR: begin
                    st_d.ptr_hi = 1'b0;
                    st_d.tc     = '0;
                    st_d.sreq   = '0;
                    st_d.mask   = '1;
                end
                OFF_UNMASK: st_d.mask = '0;
                OFF_ALLMSK: st_d.mask = wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
        st_d.tc = st_d.tc | tc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_hi_o = st_q.ptr_hi;
    assign mask_o   = st_q.mask;
    assign tc_o     = st_q.tc;
    assign sreq_o   = st_q.sreq;
    assign cmd_o    = st_q.cmd;
    assign mode_o   = st_q.mode;
endmodule

// File: rtl/legacy_dma_regs.sv
module legacy_dma_regs
    import legacy_dma_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OFF_W-1:0]         io_addr,
    input  logic [BYTE_W-1:0]        io_wdata,
    input  logic                     io_wr,
    input  logic                     io_rd,
    output logic [BYTE_W-1:0]        io_rdata,
    input  logic [NUM_CH-1:0]        dreq_i,
    input  logic [NUM_CH-1:0]        tc_i,
    output logic [NUM_CH-1:0]        mask_o,
    output logic [BYTE_W-1:0]        cmd_o,
    output logic                     ctrl_off_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH*WORD_W-1:0] base_addr_o,
    output logic [NUM_CH*WORD_W-1:0] cur_addr_o,
    output logic [NUM_CH*WORD_W-1:0] base_cnt_o,
    output logic [NUM_CH*WORD_W-1:0] cur_cnt_o
);
    logic              ptr_hi;
    logic [NUM_CH-1:0] tc_q;
    logic [NUM_CH-1:0] sreq_q;
    logic [WORD_W-1:0] ca_w [NUM_CH];
    logic [WORD_W-1:0] cc_w [NUM_CH];
    logic [CH_W-1:0]   port_ch;
    logic              port_is_cnt;
    logic              port_hit;
    logic [WORD_W-1:0] sel_word;

    assign port_hit    = !io_addr[OFF_W-1];
    assign port_ch     = io_addr[CH_W:1];
    assign port_is_cnt = io_addr[0];

    dma_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (io_wr),
        .rd_en    (io_rd),
        .addr     (io_addr),
        .wdata    (io_wdata),
        .tc_i     (tc_i),
        .ptr_hi_o (ptr_hi),
        .mask_o   (mask_o),
        .tc_o     (tc_q),
        .sreq_o   (sreq_q),
        .cmd_o    (cmd_o),
        .mode_o   (mode_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic [WORD_W-1:0] ba, bc;
        logic              hit;
        assign hit = io_wr && port_hit && (port_ch == CH_W'(g));
        dma_word_pair u_words (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_addr   (hit && !port_is_cnt),
            .ld_cnt    (hit && port_is_cnt),
            .hi_sel    (ptr_hi),
            .wbyte     (io_wdata),
            .base_addr (ba),
            .cur_addr  (ca_w[g]),
            .base_cnt  (bc),
            .cur_cnt   (cc_w[g])
        );
        assign base_addr_o[g*WORD_W +: WORD_W] = ba;
        assign cur_addr_o[g*WORD_W +: WORD_W]  = ca_w[g];
        assign base_cnt_o[g*WORD_W +: WORD_W]  = bc;
        assign cur_cnt_o[g*WORD_W +: WORD_W]   = cc_w[g];
    end

    assign ctrl_off_o = cmd_o[2];
    assign sel_word   = port_is_cnt ? cc_w[port_ch] : ca_w[port_ch];

    always_comb begin
        io_rdata = '0;
        if (io_rd && !io_wr) begin
            if (port_hit)
                io_rdata = ptr_hi ? sel_word[WORD_W-1:BYTE_W] : sel_word[BYTE_W-1:0];
            else if (io_addr == OFF_CMD)
                io_rdata = {dreq_i | sreq_q, tc_q};
        end
    end
endmodule

// File: rtl/legacy_dma_regs_chk.sv
module legacy_dma_regs_chk
    import legacy_dma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  io_addr,
    input logic [BYTE_W-1:0] io_wdata,
    input logic              io_wr,
    input logic              io_rd,
    input logic [BYTE_W-1:0] io_rdata,
    input logic [NUM_CH-1:0] tc_i,
    input logic [NUM_CH-1:0] mask_o,
    input logic              ptr_hi,
    input logic [NUM_CH-1:0] tc_q
);
    // R3: every word-port access flips the shared pointer
    a_r3_ptr_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr || io_rd) && !io_addr[OFF_W-1]) |=> (ptr_hi != $past(ptr_hi)));

    // R4: pointer reset command
    a_r4_ptr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_PTRCLR) |=> !ptr_hi);

    // R5: master clear
    a_r5_mclr: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_MCLR && tc_i == '0) |=> (mask_o == '1 && !ptr_hi && tc_q == '0));

    // R6: single mask write
    a_r6_one_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_ONEMSK) |=> (mask_o[$past(io_wdata[CH_W-1:0])] == $past(io_wdata[2])));

    // R7: all-mask clear and all-mask write
    a_r7_unmask_all: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_UNMASK) |=> (mask_o == '0));
    a_r7_write_all: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_ALLMSK) |=> (mask_o == $past(io_wdata[NUM_CH-1:0])));

    // R10: status read clears flags, pulses always land
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_wr && io_addr == OFF_CMD && tc_i == '0) |=> (tc_q == '0));
    a_r10_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i != '0) |=> ((tc_q & $past(tc_i)) == $past(tc_i)));

    // R12: quiet read bus
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0));
endmodule

bind legacy_dma_regs legacy_dma_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .tc_i     (tc_i),
    .mask_o   (mask_o),
    .ptr_hi   (ptr_hi),
    .tc_q     (tc_q)
);

// File: tb/sim_legacy_dma_regs.sv
module sim_legacy_dma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic [3:0]  dreq_i = '0;
    logic [3:0]  tc_i = '0;
    logic [3:0]  mask_o;
    logic [7:0]  cmd_o;
    logic        ctrl_off_o;
    logic [23:0] mode_o;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_a [4];
    logic [15:0] exp_c [4];
    logic [23:0] exp_mode = '0;
    logic [3:0]  exp_mask;
    logic [7:0]  got;

    always #10 clk = !clk;

    legacy_dma_regs u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #2 d = io_rdata;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic pulse_tc(input logic [3:0] v);
        @(negedge clk); tc_i = v;
        @(posedge clk); #1; tc_i = '0;
    endtask

    task automatic chk_words(input string tag);
        for (int c = 0; c < 4; c++) begin
            chk({tag, " base addr"}, 64'(base_addr_o[c*16 +: 16]), 64'(exp_a[c]));
            chk({tag, " cur addr"},  64'(cur_addr_o[c*16 +: 16]),  64'(exp_a[c]));
            chk({tag, " base cnt"},  64'(base_cnt_o[c*16 +: 16]),  64'(exp_c[c]));
            chk({tag, " cur cnt"},   64'(cur_cnt_o[c*16 +: 16]),   64'(exp_c[c]));
        end
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin exp_a[c] = '0; exp_c[c] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", 64'(mask_o), 64'hF);
        chk("R1 cmd", 64'(cmd_o), 64'h0);
        chk("R1 mode", 64'(mode_o), 64'h0);
        chk_words("R1");
        rd(4'd8, got);
        chk("R1 status", 64'(got), 64'h0);

        // R2 load every port through low then high byte
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 2; k++) begin
                logic [15:0] v;
                v = 16'hA5C3 ^ 16'(c * 16'h1111) ^ 16'(k * 16'h0FF0);
                wr(4'd12, 8'h55);
                wr(4'(2 * c + k), v[7:0]);
                wr(4'(2 * c + k), v[15:8]);
                if (k == 0) exp_a[c] = v; else exp_c[c] = v;
            end
        end
        chk_words("R2 load");
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 2; k++) begin
                logic [15:0] v;
                v = (k == 0) ? exp_a[c] : exp_c[c];
                wr(4'd12, 8'h00);
                rd(4'(2 * c + k), got);
                chk("R2 read low", 64'(got), 64'(v[7:0]));
                rd(4'(2 * c + k), got);
                chk("R2 read high", 64'(got), 64'(v[15:8]));
            end
        end

        // R3 pointer shared across ports
        wr(4'd12, 8'h00);
        wr(4'd0, 8'h11); exp_a[0][7:0] = 8'h11;
        wr(4'd3, 8'h22); exp_c[1][15:8] = 8'h22;
        chk_words("R3 shared");
        rd(4'd0, got);
        chk("R3 read after write pair", 64'(got), 64'h11);
        rd(4'd0, got);
        chk("R3 second read high", 64'(got), 64'(exp_a[0][15:8]));

        // R4 pointer clear after high-byte state, data ignored
        wr(4'd0, 8'h5A); exp_a[0][7:0] = 8'h5A;
        wr(4'd12, 8'hFF);
        wr(4'd2, 8'h77); exp_a[1][7:0] = 8'h77;
        chk_words("R4");

        // R7 all-mask write sweep, then clear-all
        for (int m = 0; m < 16; m++) begin
            wr(4'd15, 8'(m) | 8'hF0);
            chk("R7 all-mask write", 64'(mask_o), 64'(m));
        end
        wr(4'd14, 8'hFF);
        chk("R7 clear all", 64'(mask_o), 64'h0);

        // R6 single mask set then clear
        exp_mask = '0;
        for (int c = 0; c < 4; c++) begin
            wr(4'd10, 8'(c) | 8'h04);
            exp_mask[c] = 1'b1;
            chk("R6 mask set", 64'(mask_o), 64'(exp_mask));
        end
        for (int c = 0; c < 4; c++) begin
            wr(4'd10, 8'(c) | 8'hF0);
            exp_mask[c] = 1'b0;
            chk("R6 mask clear", 64'(mask_o), 64'(exp_mask));
        end

        // R8 modes
        for (int c = 0; c < 4; c++) begin
            logic [7:0] m;
            m = 8'(c * 8'h4B + 8'h36);
            wr(4'd11, {m[7:2], 2'(c)});
            exp_mode[c*6 +: 6] = m[7:2];
            chk("R8 mode", 64'(mode_o), 64'(exp_mode));
        end

        // R9 command
        wr(4'd8, 8'h04);
        chk("R9 cmd", 64'(cmd_o), 64'h04);
        chk("R9 disable on", 64'(ctrl_off_o), 64'h1);
        wr(4'd8, 8'hFB);
        chk("R9 cmd", 64'(cmd_o), 64'hFB);
        chk("R9 disable off", 64'(ctrl_off_o), 64'h0);

        // R10 status flags and clear-on-read
        dreq_i = 4'b1010;
        pulse_tc(4'b0101);
        rd(4'd8, got);
        chk("R10 status", 64'(got), 64'hA5);
        rd(4'd8, got);
        chk("R10 cleared by read", 64'(got), 64'hA0);
        // R11 software request
        wr(4'd9, 8'h04);
        rd(4'd8, got);
        chk("R11 sw request set", 64'(got), 64'hB0);
        wr(4'd9, 8'hF8 & 8'hFB);
        rd(4'd8, got);
        chk("R11 sw request clear", 64'(got), 64'hA0);
        // R10 pulse coinciding with clearing read
        @(negedge clk);
        io_addr = 4'd8; io_rd = 1'b1; tc_i = 4'b0010;
        #2 got = io_rdata;
        @(posedge clk); #1;
        io_rd = 1'b0; tc_i = '0;
        chk("R10 read before pulse", 64'(got), 64'hA0);
        rd(4'd8, got);
        chk("R10 pulse kept", 64'(got), 64'hA2);

        // R5 master clear
        wr(4'd12, 8'h00);
        wr(4'd0, 8'h3C); exp_a[0][7:0] = 8'h3C;
        wr(4'd14, 8'h00);
        wr(4'd9, 8'h07);
        pulse_tc(4'b1000);
        wr(4'd13, 8'h00);
        chk("R5 masks set", 64'(mask_o), 64'hF);
        rd(4'd8, got);
        chk("R5 status cleared", 64'(got), 64'hA0);
        wr(4'd0, 8'h9C); exp_a[0][7:0] = 8'h9C;
        chk_words("R5 pointer low");

        // R12 read bus
        for (int a = 9; a < 16; a++) begin
            rd(4'(a), got);
            chk("R12 unused read", 64'(got), 64'h0);
        end
        @(negedge clk);
        io_addr = 4'd8;
        #2 chk("R12 idle bus", 64'(io_rdata), 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule